// File: doc/BRIEF.md
# Segmented Data Address Generator

This block forms the physical data-memory address for a small 8-bit controller core. Each access cycle names one of five address sources: a direct byte address carried by the instruction, either of two indirect pointers, or the stack pointer for a push or a pop. The block maps the resulting 8-bit effective address onto a 16-bit physical address. Effective addresses in the lower half (0x00 to 0x7F) are banked by an 8-bit segment register into 256 pages of 128 bytes. Effective addresses in the upper half go to one common window that the segment register never moves.

The two indirect pointers can step up or down by one after the access that uses them, and the step wraps modulo 256. The stack pointer starts at 0x6F and is post-decremented on a push and pre-incremented on a pop, so one pop undoes one push. Stack traffic always lands in segment 0, whatever the segment register holds. All four registers belong to the data space. The core writes them through a write port that takes effect on the next cycle, and reads them through a combinational read port. The physical address is registered and appears one cycle after the request, together with a valid flag.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is held and after it is released, pointer A (select 0) and pointer B (select 1) read 0x00, the stack pointer (select 2) reads 0x6F, the segment register (select 3) reads 0x00, and phys_valid is 0.
- R2: A request with acc_en=1 and acc_mode=0 (direct) makes phys_valid 1 on the next cycle, with the address of dir_addr. acc_upd has no effect on any register for a direct request.
- R3: For an effective address e below 0x80, the physical address is {1'b0, seg, e[6:0]}, that is seg*128 + e. seg is the segment register for direct and pointer requests and 0 for stack requests.
- R4: For an effective address e of 0x80 or more, the physical address is 0xFF00 | e, independent of the segment register.
- R5: acc_mode=1 (pointer A) and acc_mode=2 (pointer B) use the pointer's value before the request as the effective address. acc_upd=1 then adds one, acc_upd=2 subtracts one, and 0 or 3 leaves the pointer as it was. The arithmetic wraps modulo 256.
- R6: acc_mode=3 (push) addresses the current stack pointer and then decrements it. acc_mode=4 (pop) increments the stack pointer first and addresses the new value. A pop undoes a push exactly, and both wrap modulo 256.
- R7: A register write (reg_wr_en=1, select as in R1) is visible on reg_rd_data and used by requests from the next cycle on. A request in the same cycle sees the old value.
- R8: When a write and an access update target the same register in the same cycle, the written value is kept.
- R9: acc_en=0, or acc_mode values 5 to 7, give phys_valid 0 on the next cycle and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access request this cycle |
| acc_mode | input | 3 | Address source: 0 direct, 1 pointer A, 2 pointer B, 3 push, 4 pop |
| acc_upd | input | 2 | Pointer step after use: 1 increment, 2 decrement, else none |
| dir_addr | input | 8 | Direct effective address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register to write: 0 A, 1 B, 2 stack, 3 segment |
| reg_wr_data | input | 8 | Value to write |
| reg_rd_sel | input | 2 | Register to read, same coding |
| reg_rd_data | output | 8 | Current value of the selected register |
| phys_addr | output | 16 | Registered physical data address |
| phys_valid | output | 1 | phys_addr belongs to a request of the previous cycle |

## Verification
The hardest case to reach is a write and an automatic update landing on the same register in one cycle, together with the wrap of a pointer or the stack pointer across 0x00/0xFF. The stimulus first loads each pointer with an edge value through the write port. It then issues requests with a step in the same direction as the wrap, and in one cycle combines a pointer request with a write to that same pointer. Stack pushes made while a nonzero segment is active show whether stack traffic escapes the banking.

// File: rtl/sag_pkg.sv
package sag_pkg;

    parameter int unsigned SAG_AW = 8;   // effective address / pointer width
    parameter int unsigned SAG_SW = 8;   // segment register width

    typedef enum logic [2:0] {
        AM_DIRECT = 3'd0,
        AM_PTR_A  = 3'd1,
        AM_PTR_B  = 3'd2,
        AM_PUSH   = 3'd3,
        AM_POP    = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        PU_NONE = 2'd0,
        PU_INC  = 2'd1,
        PU_DEC  = 2'd2,
        PU_KEEP = 2'd3
    } pupd_e;

    typedef enum logic [1:0] {
        RS_PTR_A = 2'd0,
        RS_PTR_B = 2'd1,
        RS_STACK = 2'd2,
        RS_SEG   = 2'd3
    } rsel_e;

endpackage

// File: rtl/sag_ptr_step.sv
module sag_ptr_step #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         apply,
    input  logic [1:0]   upd,
    output logic [W-1:0] nxt
);
    import sag_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        nxt = cur;
        if (apply) begin
            unique case (pupd_e'(upd))
                PU_INC:  nxt = cur + ONE;
                PU_DEC:  nxt = cur - ONE;
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/sag_stack_step.sv
module sag_stack_step #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] sp,
    input  logic         push,
    input  logic         pop,
    output logic [W-1:0] eff,
    output logic [W-1:0] sp_nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] sp_up;

    // push: use then decrement; pop: increment then use
    always_comb begin
        sp_up  = sp + ONE;
        eff    = pop ? sp_up : sp;
        sp_nxt = sp;
        if (push)     sp_nxt = sp - ONE;
        else if (pop) sp_nxt = sp_up;
    end
endmodule

// File: rtl/sag_seg_map.sv
module sag_seg_map #(
    parameter int unsigned AW = 8,
    parameter int unsigned SW = 8,
    parameter int unsigned PW = SW + AW
) (
    input  logic [AW-1:0] eff,
    input  logic [SW-1:0] seg,
    output logic [PW-1:0] phys
);
    localparam logic [SW-1:0] COMMON_HI = {SW{1'b1}};

    always_comb begin
        if (eff[AW-1]) phys = {COMMON_HI, eff};
        else           phys = {1'b0, seg, eff[AW-2:0]};
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int unsigned AW       = sag_pkg::SAG_AW,
    parameter int unsigned SW       = sag_pkg::SAG_SW,
    parameter logic [AW-1:0] SP_RST = AW'(8'h6F),
    localparam int unsigned PW      = SW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic [2:0]    acc_mode,
    input  logic [1:0]    acc_upd,
    input  logic [AW-1:0] dir_addr,
    input  logic          reg_wr_en,
    input  logic [1:0]    reg_wr_sel,
    input  logic [AW-1:0] reg_wr_data,
    input  logic [1:0]    reg_rd_sel,
    output logic [AW-1:0] reg_rd_data,
    output logic [PW-1:0] phys_addr,
    output logic          phys_valid
);
    import sag_pkg::*;

    typedef struct packed {
        logic [AW-1:0] pa;
        logic [AW-1:0] pb;
        logic [AW-1:0] sp;
        logic [SW-1:0] seg;
        logic [PW-1:0] addr;
        logic          valid;
    } sag_state_t;

    sag_state_t st_d, st_q;

    logic          sel_dir, sel_a, sel_b, sel_push, sel_pop, acc_ok;
    logic [AW-1:0] pa_step, pb_step, sp_step, stk_eff;
    logic [AW-1:0] eff_sel;
    logic [SW-1:0] seg_sel;
    logic [PW-1:0] phys_map;

    always_comb begin
        sel_dir  = acc_en && (amode_e'(acc_mode) == AM_DIRECT);
        sel_a    = acc_en && (amode_e'(acc_mode) == AM_PTR_A);
        sel_b    = acc_en && (amode_e'(acc_mode) == AM_PTR_B);
        sel_push = acc_en && (amode_e'(acc_mode) == AM_PUSH);
        sel_pop  = acc_en && (amode_e'(acc_mode) == AM_POP);
        acc_ok   = sel_dir | sel_a | sel_b | sel_push | sel_pop;
    end

    sag_ptr_step #(.W(AW)) u_step_a (
        .cur(st_q.pa), .apply(sel_a), .upd(acc_upd), .nxt(pa_step)
    );

    sag_ptr_step #(.W(AW)) u_step_b (
        .cur(st_q.pb), .apply(sel_b), .upd(acc_upd), .nxt(pb_step)
    );

    sag_stack_step #(.W(AW)) u_stack (
        .sp(st_q.sp), .push(sel_push), .pop(sel_pop),
        .eff(stk_eff), .sp_nxt(sp_step)
    );

    always_comb begin
        eff_sel = dir_addr;
        seg_sel = st_q.seg;
        if (sel_a)               eff_sel = st_q.pa;
        else if (sel_b)          eff_sel = st_q.pb;
        else if (sel_push | sel_pop) begin
            eff_sel = stk_eff;
            seg_sel = '0;        // stack lives in segment 0
        end
    end

    sag_seg_map #(.AW(AW), .SW(SW), .PW(PW)) u_map (
        .eff(eff_sel), .seg(seg_sel), .phys(phys_map)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pa    = pa_step;
        st_d.pb    = pb_step;
        st_d.sp    = sp_step;
        st_d.valid = acc_ok;
        if (acc_ok) st_d.addr = phys_map;
        // data-bus write wins over any same-cycle automatic update
        if (reg_wr_en) begin
            unique case (rsel_e'(reg_wr_sel))
                RS_PTR_A: st_d.pa  = reg_wr_data;
                RS_PTR_B: st_d.pb  = reg_wr_data;
                RS_STACK: st_d.sp  = reg_wr_data;
                RS_SEG:   st_d.seg = SW'(reg_wr_data);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pa    <= '0;
            st_q.pb    <= '0;
            st_q.sp    <= SP_RST;
            st_q.seg   <= '0;
            st_q.addr  <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (rsel_e'(reg_rd_sel))
            RS_PTR_A: reg_rd_data = st_q.pa;
            RS_PTR_B: reg_rd_data = st_q.pb;
            RS_STACK: reg_rd_data = st_q.sp;
            RS_SEG:   reg_rd_data = AW'(st_q.seg);
            default:  reg_rd_data = '0;
        endcase
    end

    assign phys_addr  = st_q.addr;
    assign phys_valid = st_q.valid;

endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
    parameter int unsigned AW = 8,
    parameter int unsigned PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_en,
    input logic [2:0]    acc_mode,
    input logic [AW-1:0] dir_addr,
    input logic          reg_wr_en,
    input logic [1:0]    reg_wr_sel,
    input logic [AW-1:0] reg_wr_data,
    input logic [1:0]    reg_rd_sel,
    input logic [AW-1:0] reg_rd_data,
    input logic [PW-1:0] phys_addr,
    input logic          phys_valid
);
    localparam int unsigned HI = PW - AW;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !phys_valid);

    assert_direct_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 3'd0 && !dir_addr[AW-1]) |=>
            (phys_valid && !phys_addr[PW-1] &&
             phys_addr[AW-2:0] == $past(dir_addr[AW-2:0])));

    assert_direct_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 3'd0 && dir_addr[AW-1]) |=>
            (phys_valid && phys_addr[AW-1:0] == $past(dir_addr) &&
             phys_addr[PW-1:AW] == {HI{1'b1}}));

    assert_write_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel == reg_rd_sel) |=>
            (reg_rd_sel != $past(reg_rd_sel) || reg_rd_data == $past(reg_wr_data)));

    assert_no_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en || acc_mode > 3'd4) |=> !phys_valid);

endmodule

bind seg_addr_gen sag_checker #(.AW(AW), .PW(PW)) u_sag_checker (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_mode(acc_mode),
    .dir_addr(dir_addr), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel),
    .reg_rd_data(reg_rd_data), .phys_addr(phys_addr), .phys_valid(phys_valid)
);

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [2:0]  acc_mode = 3'd0;
    logic [1:0]  acc_upd = 2'd0;
    logic [7:0]  dir_addr = 8'd0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = 2'd0;
    logic [7:0]  reg_wr_data = 8'd0;
    logic [1:0]  reg_rd_sel = 2'd0;
    logic [7:0]  reg_rd_data;
    logic [15:0] phys_addr;
    logic        phys_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          due;
        bit          vld;
        logic [15:0] addr;
        string       req;
    } exp_t;

    exp_t sb[$];

    // bench-side register model
    logic [7:0] m_a, m_b, m_sp, m_seg;

    always #4 clk = ~clk;   // 125 MHz

    seg_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_mode(acc_mode),
        .acc_upd(acc_upd), .dir_addr(dir_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .phys_addr(phys_addr), .phys_valid(phys_valid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] map_addr(input logic [7:0] e, input logic [7:0] s);
        if (e >= 8'h80) return 16'hFF00 | {8'h00, e};
        return {8'h00, 1'b0, e[6:0]} + ({8'h00, s} << 7);
    endfunction

    // monitor: compare each due scoreboard item
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (phys_valid !== it.vld || (it.vld && phys_addr !== it.addr)) begin
                errors++;
                $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
                         it.req, phys_valid, phys_addr, it.vld, it.addr);
            end
        end
    end

    task automatic step(input bit en, input logic [2:0] mode, input logic [1:0] upd,
                        input logic [7:0] da, input bit wen, input logic [1:0] wsel,
                        input logic [7:0] wd, input string req);
        exp_t it;
        logic [7:0] e;
        bit v;
        @(negedge clk);
        acc_en = en; acc_mode = mode; acc_upd = upd; dir_addr = da;
        reg_wr_en = wen; reg_wr_sel = wsel; reg_wr_data = wd;
        v = en && (mode <= 3'd4);
        e = da;
        it.due = cyc + 1; it.vld = v; it.req = req; it.addr = 16'h0;
        case (mode)
            3'd0: it.addr = map_addr(da, m_seg);
            3'd1: begin it.addr = map_addr(m_a, m_seg); e = m_a; end
            3'd2: begin it.addr = map_addr(m_b, m_seg); e = m_b; end
            3'd3: it.addr = map_addr(m_sp, 8'h00);
            3'd4: it.addr = map_addr(m_sp + 8'd1, 8'h00);
            default: ;
        endcase
        if (v) begin
            if (mode == 3'd1 && upd == 2'd1) m_a = e + 8'd1;
            if (mode == 3'd1 && upd == 2'd2) m_a = e - 8'd1;
            if (mode == 3'd2 && upd == 2'd1) m_b = e + 8'd1;
            if (mode == 3'd2 && upd == 2'd2) m_b = e - 8'd1;
            if (mode == 3'd3) m_sp = m_sp - 8'd1;
            if (mode == 3'd4) m_sp = m_sp + 8'd1;
        end
        if (wen) begin
            case (wsel)
                2'd0: m_a = wd;
                2'd1: m_b = wd;
                2'd2: m_sp = wd;
                default: m_seg = wd;
            endcase
        end
        sb.push_back(it);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        step(1'b0, 3'd0, 2'd0, 8'h00, 1'b1, sel, d, "R9 write-only cycle");
    endtask

    task automatic chk_reg(input logic [1:0] sel, input string req);
        logic [7:0] ex;
        @(negedge clk);
        acc_en = 1'b0; reg_wr_en = 1'b0; reg_rd_sel = sel;
        case (sel)
            2'd0: ex = m_a;
            2'd1: ex = m_b;
            2'd2: ex = m_sp;
            default: ex = m_seg;
        endcase
        #1;
        checks++;
        if (reg_rd_data !== ex) begin
            errors++;
            $display("FAIL %s: reg %0d read %h expected %h", req, sel, reg_rd_data, ex);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_a = 8'h00; m_b = 8'h00; m_sp = 8'h6F; m_seg = 8'h00;
        repeat (3) @(posedge clk);
        // R1: values while in reset
        for (int r = 0; r < 4; r++) chk_reg(r[1:0], "R1 in reset");
        checks++;
        if (phys_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: phys_valid=%0b expected 0", phys_valid);
        end
        @(negedge clk); rst_n = 1'b1;
        for (int r = 0; r < 4; r++) chk_reg(r[1:0], "R1 after release");

        // R2/R3 with segment 0, then segment 5 loaded
        step(1'b1, 3'd0, 2'd1, 8'h35, 1'b0, 2'd0, 8'h00, "R2 direct seg0");
        wr(2'd3, 8'h05);
        wr(2'd0, 8'h10);
        wr(2'd1, 8'hF0);
        step(1'b1, 3'd0, 2'd1, 8'h20, 1'b0, 2'd0, 8'h00, "R3 direct seg5");
        chk_reg(2'd0, "R2 upd ignored on direct");
        chk_reg(2'd1, "R2 upd ignored on direct");
        step(1'b1, 3'd0, 2'd2, 8'h90, 1'b0, 2'd0, 8'h00, "R4 upper half");
        for (int i = 0; i < 16; i++)
            step(1'b1, 3'd0, 2'd0, 8'(i * 17), 1'b0, 2'd0, 8'h00, "R3/R4 direct sweep");

        // R5 pointers
        step(1'b1, 3'd1, 2'd1, 8'h00, 1'b0, 2'd0, 8'h00, "R5 A post-inc");
        step(1'b1, 3'd1, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, "R5 A after inc");
        step(1'b1, 3'd2, 2'd2, 8'h00, 1'b0, 2'd0, 8'h00, "R5 B post-dec upper");
        step(1'b1, 3'd2, 2'd3, 8'h00, 1'b0, 2'd0, 8'h00, "R5 B keep");
        chk_reg(2'd0, "R5 A value");
        chk_reg(2'd1, "R5 B value");
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h00);
        step(1'b1, 3'd1, 2'd1, 8'h00, 1'b0, 2'd0, 8'h00, "R5 A wrap up");
        step(1'b1, 3'd2, 2'd2, 8'h00, 1'b0, 2'd0, 8'h00, "R5 B wrap down");
        chk_reg(2'd0, "R5 A wrapped to 00");
        chk_reg(2'd1, "R5 B wrapped to FF");
        step(1'b1, 3'd1, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, "R5 A use wrapped");
        step(1'b1, 3'd2, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, "R5 B use wrapped");

        // R6 stack with nonzero segment
        step(1'b1, 3'd3, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, "R6 push 1");
        step(1'b1, 3'd3, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, "R6 push 2");
        chk_reg(2'd2, "R6 sp after pushes");
        step(1'b1, 3'd4, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, "R6 pop 1");
        step(1'b1, 3'd4, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, "R6 pop 2");
        chk_reg(2'd2, "R6 sp restored");
        wr(2'd2, 8'h00);
        step(1'b1, 3'd3, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, "R6 push wrap");
        chk_reg(2'd2, "R6 sp wrapped to FF");
        step(1'b1, 3'd4, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, "R6 pop wrap");
        chk_reg(2'd2, "R6 sp back to 00");

        // R7 write timing: same-cycle access sees old segment, next sees new
        step(1'b1, 3'd0, 2'd0, 8'h11, 1'b1, 2'd3, 8'h2A, "R7 same-cycle old seg");
        step(1'b1, 3'd0, 2'd0, 8'h11, 1'b0, 2'd0, 8'h00, "R7 next-cycle new seg");
        chk_reg(2'd3, "R7 seg readback");

        // R8 write beats same-cycle update
        wr(2'd0, 8'h40);
        step(1'b1, 3'd1, 2'd1, 8'h00, 1'b1, 2'd0, 8'h77, "R8 A write vs inc");
        chk_reg(2'd0, "R8 A holds written value");
        step(1'b1, 3'd3, 2'd0, 8'h00, 1'b1, 2'd2, 8'h50, "R8 sp write vs push");
        chk_reg(2'd2, "R8 sp holds written value");

        // R9 no request
        step(1'b0, 3'd1, 2'd1, 8'h00, 1'b0, 2'd0, 8'h00, "R9 acc_en low");
        step(1'b1, 3'd5, 2'd1, 8'h00, 1'b0, 2'd0, 8'h00, "R9 mode 5");
        step(1'b1, 3'd7, 2'd2, 8'h00, 1'b0, 2'd0, 8'h00, "R9 mode 7");
        for (int r = 0; r < 4; r++) chk_reg(r[1:0], "R9 registers unchanged");

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left expected 0", sb.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule